// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one programmable logic cell of the kind tiled across a product-term logic array. A single logic term enters the cell: either the product-term sum or a bypass term. A polarity and XOR stage shapes it, and the result feeds a storage element. A direct pad input can take the place of that result as the storage data input, so the cell can act as a fast input register. The storage element works as an edge-triggered D flip-flop or as a transparent D latch.

Clock, clock enable, reset and preset are each picked from global or product-term sources. The clock is never gated. A disabled cell simply keeps its stored value. The cell drives two outputs at the same time, one towards the routing pool and one towards the I/O path. Each output can carry either the stored value or the combinational result, independently of the other.

The cell runs on a fast system clock `clk`, which samples the selected cell clock as a level. A rising edge of the cell clock is detected from two consecutive samples. All configuration is static. It is captured while `rst_n` is low.

Top module: `mc_cell`

## Requirements
- R1: The combinational result is computed from a source term, which is `bypass_i` when cfg bit 14 is 1 and `pt_sum_i` otherwise. Cfg bits [1:0] set the operation: 0 passes the source, 1 inverts it, 2 gives source XOR `pt_xor_i`, and 3 gives the inverse of that XOR.
- R2: When cfg bit 2 is 1, `pad_i` is the storage data input. When it is 0, the combinational result is the storage data input. The combinational result itself is unaffected by this bit.
- R3: With cfg bit 3 = 0 (flip-flop), the stored value takes the data input at a `clk` edge when the selected cell clock is sampled high, its previous sample was low, and the enable is true. Otherwise the stored value is kept.
- R4: With cfg bit 3 = 1 (latch), the stored value takes the data input at every `clk` edge where the selected cell clock is high and the enable is true. It is held while the cell clock is low.
- R5: Cfg bits [6:4] select the cell clock: codes 0 to 3 pick `gclk_i[0]` to `gclk_i[3]`, 4 picks `pt_clk_i`, 5 picks `sh_clk_i`, and 6 and 7 pick a constant low.
- R6: Cfg bits [8:7] select the enable: 0 is always enabled, 1 is `gce_i`, 2 is `sh_ce_i`, and 3 is `gce_i` AND `sh_ce_i`. A false enable keeps the stored value.
- R7: Cfg bits [10:9] select the cell reset: 0 is none, 1 is `grst_i`, 2 is `pt_rst_i`, and 3 is `sh_rst_i`. An active reset clears the stored value at the next `clk` edge, whatever the clock and enable are doing.
- R8: When cfg bit 11 is 1, `pt_pre_i` sets the stored value to 1 at the next `clk` edge, whatever the clock and enable are doing. An active cell reset wins over the preset.
- R9: `route_o` carries the stored value when cfg bit 12 is 1 and the combinational result otherwise. `io_o` makes the same choice from cfg bit 13, independently of `route_o`.
- R10: `cfg_i` is captured on every `clk` edge with `rst_n` low and is ignored while `rst_n` is high. `rst_n` low clears the stored value and the clock history to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset; captures configuration |
| cfg_i | input | 15 | Static configuration word |
| pt_sum_i | input | 1 | Product-term sum |
| bypass_i | input | 1 | Bypass logic term |
| pt_xor_i | input | 1 | Product term for the XOR stage |
| pad_i | input | 1 | Direct input from the pad |
| gclk_i | input | 4 | Global clocks |
| pt_clk_i | input | 1 | Per-cell product-term clock |
| sh_clk_i | input | 1 | Shared product-term clock |
| gce_i | input | 1 | Global clock enable |
| sh_ce_i | input | 1 | Shared product-term clock enable |
| grst_i | input | 1 | Global reset |
| pt_rst_i | input | 1 | Per-cell product-term reset |
| sh_rst_i | input | 1 | Shared product-term reset |
| pt_pre_i | input | 1 | Product-term preset |
| route_o | output | 1 | Output to the routing pool |
| io_o | output | 1 | Output to the I/O path |

## Verification
The storage element can receive a capture, a reset and a preset in one `clk` cycle. This happens when the selected cell clock rises or stays high in latch mode while the chosen reset and preset lines are also active. The sweep drives every reset, preset, clock and enable line from a pseudo-random stream in every configuration, so all of these collisions occur. Each outcome is judged against a bench model with the priority reset, then preset, then capture. The same cycles also exercise the combinational path on the other output, so a stored and a combinational result are checked side by side.

// File: rtl/mc_pkg.sv
// mc_pkg: shared types for the logic macrocell.
// Assumes one cell per instance; configuration layout is fixed here.
package mc_pkg;

    localparam int MC_NUM_GCLK   = 4;
    localparam int MC_CLK_SEL_W  = 3;

    typedef enum logic [1:0] {
        XOR_PASS  = 2'd0,
        XOR_INV   = 2'd1,
        XOR_PT    = 2'd2,
        XOR_PT_N  = 2'd3
    } xor_mode_e;

    typedef enum logic [1:0] {
        CE_ON   = 2'd0,
        CE_GLB  = 2'd1,
        CE_SHR  = 2'd2,
        CE_BOTH = 2'd3
    } ce_sel_e;

    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_GLB  = 2'd1,
        RS_CELL = 2'd2,
        RS_SHR  = 2'd3
    } rst_sel_e;

    // Packed MSB first; the last field sits at bit 0.
    typedef struct packed {
        logic                    sum_bypass;
        logic                    io_reg;
        logic                    route_reg;
        logic                    pre_en;
        rst_sel_e                rst_sel;
        ce_sel_e                 ce_sel;
        logic [MC_CLK_SEL_W-1:0] clk_sel;
        logic                    latch_mode;
        logic                    data_sel;
        xor_mode_e               xor_mode;
    } mc_cfg_t;

    localparam int MC_CFG_W = $bits(mc_cfg_t);

endpackage

// File: rtl/mc_data_path.sv
// mc_data_path: source choice, polarity/XOR stage and storage data select.
// Assumes configuration fields are static after reset.
module mc_data_path
    import mc_pkg::*;
(
    input  logic      sum_bypass,
    input  xor_mode_e xor_mode,
    input  logic      data_sel,
    input  logic      pt_sum_i,
    input  logic      bypass_i,
    input  logic      pt_xor_i,
    input  logic      pad_i,
    output logic      comb_o,
    output logic      d_o
);

    logic src;

    // Pick the logic term and apply the configured XOR operation.
    always_comb begin
        src = sum_bypass ? bypass_i : pt_sum_i;
        unique case (xor_mode)
            XOR_PASS: comb_o = src;
            XOR_INV:  comb_o = ~src;
            XOR_PT:   comb_o = src ^ pt_xor_i;
            XOR_PT_N: comb_o = ~(src ^ pt_xor_i);
            default:  comb_o = src;
        endcase
    end

    // Choose the storage data input: pad or combinational result.
    always_comb d_o = data_sel ? pad_i : comb_o;

endmodule

// File: rtl/mc_ctrl_select.sv
// mc_ctrl_select: chooses cell clock, enable, reset and preset sources and
// detects rising edges of the chosen clock by sampling it on clk.
// Assumes the cell clock is slower than clk, so each of its levels is seen
// for at least one clk cycle.
module mc_ctrl_select
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = MC_NUM_GCLK
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MC_CLK_SEL_W-1:0] clk_sel,
    input  ce_sel_e                 ce_sel,
    input  rst_sel_e                rst_sel,
    input  logic                    pre_en,
    input  logic [NUM_GCLK-1:0]     gclk_i,
    input  logic                    pt_clk_i,
    input  logic                    sh_clk_i,
    input  logic                    gce_i,
    input  logic                    sh_ce_i,
    input  logic                    grst_i,
    input  logic                    pt_rst_i,
    input  logic                    sh_rst_i,
    input  logic                    pt_pre_i,
    output logic                    sel_clk_o,
    output logic                    edge_o,
    output logic                    ce_o,
    output logic                    cell_rst_o,
    output logic                    cell_pre_o
);

    localparam int SRC_N = NUM_GCLK + 2;

    logic [SRC_N-1:0] clk_src;
    logic             clk_prev;

    assign clk_src = {sh_clk_i, pt_clk_i, gclk_i};

    // Clock source mux; codes past the last source give a constant low.
    always_comb begin
        sel_clk_o = 1'b0;
        for (int i = 0; i < SRC_N; i++) begin
            if (int'(clk_sel) == i) sel_clk_o = clk_src[i];
        end
    end

    // Remember the previous sample of the selected clock.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= sel_clk_o;
    end

    // Rising edge of the cell clock.
    always_comb edge_o = sel_clk_o & ~clk_prev;

    // Clock enable source select.
    always_comb begin
        unique case (ce_sel)
            CE_ON:   ce_o = 1'b1;
            CE_GLB:  ce_o = gce_i;
            CE_SHR:  ce_o = sh_ce_i;
            CE_BOTH: ce_o = gce_i & sh_ce_i;
            default: ce_o = 1'b1;
        endcase
    end

    // Reset source select.
    always_comb begin
        unique case (rst_sel)
            RS_NONE: cell_rst_o = 1'b0;
            RS_GLB:  cell_rst_o = grst_i;
            RS_CELL: cell_rst_o = pt_rst_i;
            RS_SHR:  cell_rst_o = sh_rst_i;
            default: cell_rst_o = 1'b0;
        endcase
    end

    // Preset gating.
    always_comb cell_pre_o = pre_en & pt_pre_i;

    // An edge is never reported on two consecutive samples.
    assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/mc_storage.sv
// mc_storage: the cell's storage bit, working as a flip-flop or a latch.
// Priority: cell reset, then preset, then capture. Assumes all controls are
// already sampled-domain signals from mc_ctrl_select.
module mc_storage (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_mode,
    input  logic sel_clk,
    input  logic clk_edge,
    input  logic ce,
    input  logic cell_rst,
    input  logic cell_pre,
    input  logic d,
    output logic q_o
);

    logic capture;

    // Capture condition: rising edge for a flip-flop, high level for a latch.
    always_comb capture = ce & (latch_mode ? sel_clk : clk_edge);

    // Update the stored bit with reset over preset over capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        q_o <= 1'b0;
        else if (cell_rst) q_o <= 1'b0;
        else if (cell_pre) q_o <= 1'b1;
        else if (capture)  q_o <= d;
    end

    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_rst |=> (q_o == 1'b0));

    assert_preset_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_pre && !cell_rst) |=> (q_o == 1'b1));

    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !cell_rst && !cell_pre) |=> $stable(q_o));

    assert_ff_no_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && !clk_edge && !cell_rst && !cell_pre) |=> $stable(q_o));

    assert_latch_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && sel_clk && ce && !cell_rst && !cell_pre) |=> (q_o == $past(d)));

endmodule

// File: rtl/mc_cell.sv
// mc_cell: configurable logic macrocell. Captures its static configuration
// while rst_n is low and drives two independent outputs, each carrying the
// stored or the combinational result.
module mc_cell
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = MC_NUM_GCLK
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MC_CFG_W-1:0] cfg_i,
    input  logic                pt_sum_i,
    input  logic                bypass_i,
    input  logic                pt_xor_i,
    input  logic                pad_i,
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic                pt_clk_i,
    input  logic                sh_clk_i,
    input  logic                gce_i,
    input  logic                sh_ce_i,
    input  logic                grst_i,
    input  logic                pt_rst_i,
    input  logic                sh_rst_i,
    input  logic                pt_pre_i,
    output logic                route_o,
    output logic                io_o
);

    mc_cfg_t cfg_q;
    logic    comb_val;
    logic    d_val;
    logic    sel_clk;
    logic    clk_edge;
    logic    ce;
    logic    cell_rst;
    logic    cell_pre;
    logic    q_val;

    // Capture configuration only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= mc_cfg_t'(cfg_i);
    end

    mc_data_path u_data (
        .sum_bypass (cfg_q.sum_bypass),
        .xor_mode   (cfg_q.xor_mode),
        .data_sel   (cfg_q.data_sel),
        .pt_sum_i   (pt_sum_i),
        .bypass_i   (bypass_i),
        .pt_xor_i   (pt_xor_i),
        .pad_i      (pad_i),
        .comb_o     (comb_val),
        .d_o        (d_val)
    );

    mc_ctrl_select #(.NUM_GCLK(NUM_GCLK)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_sel    (cfg_q.clk_sel),
        .ce_sel     (cfg_q.ce_sel),
        .rst_sel    (cfg_q.rst_sel),
        .pre_en     (cfg_q.pre_en),
        .gclk_i     (gclk_i),
        .pt_clk_i   (pt_clk_i),
        .sh_clk_i   (sh_clk_i),
        .gce_i      (gce_i),
        .sh_ce_i    (sh_ce_i),
        .grst_i     (grst_i),
        .pt_rst_i   (pt_rst_i),
        .sh_rst_i   (sh_rst_i),
        .pt_pre_i   (pt_pre_i),
        .sel_clk_o  (sel_clk),
        .edge_o     (clk_edge),
        .ce_o       (ce),
        .cell_rst_o (cell_rst),
        .cell_pre_o (cell_pre)
    );

    mc_storage u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_mode (cfg_q.latch_mode),
        .sel_clk    (sel_clk),
        .clk_edge   (clk_edge),
        .ce         (ce),
        .cell_rst   (cell_rst),
        .cell_pre   (cell_pre),
        .d          (d_val),
        .q_o        (q_val)
    );

    // Each output picks stored or combinational result on its own.
    always_comb begin
        route_o = cfg_q.route_reg ? q_val : comb_val;
        io_o    = cfg_q.io_reg    ? q_val : comb_val;
    end

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(cfg_q));

endmodule

// File: tb/sim_mc_cell.sv
// sim_mc_cell: sweeps 512 configurations with pseudo-random stimulus and
// compares both outputs every cycle against a model built from the brief.
module sim_mc_cell;

    localparam int CLK_PERIOD  = 10;
    localparam int CYC_PER_CFG = 40;
    localparam int N_CFG       = 512;
    localparam int WATCHDOG    = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] cfg_i;
    logic        pt_sum_i, bypass_i, pt_xor_i, pad_i;
    logic [3:0]  gclk_i;
    logic        pt_clk_i, sh_clk_i, gce_i, sh_ce_i;
    logic        grst_i, pt_rst_i, sh_rst_i, pt_pre_i;
    logic        route_o, io_o;

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [31:0] rnd    = 32'h1ACE_5EED;
    logic        m_q, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    mc_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
        .pt_sum_i(pt_sum_i), .bypass_i(bypass_i), .pt_xor_i(pt_xor_i), .pad_i(pad_i),
        .gclk_i(gclk_i), .pt_clk_i(pt_clk_i), .sh_clk_i(sh_clk_i),
        .gce_i(gce_i), .sh_ce_i(sh_ce_i),
        .grst_i(grst_i), .pt_rst_i(pt_rst_i), .sh_rst_i(sh_rst_i), .pt_pre_i(pt_pre_i),
        .route_o(route_o), .io_o(io_o)
    );

    function automatic logic [31:0] next_rand(logic [31:0] s);
        s = s ^ (s << 13);
        s = s ^ (s >> 17);
        s = s ^ (s << 5);
        return s;
    endfunction

    // R1: expected combinational result.
    function automatic logic f_comb(logic [14:0] c);
        logic src;
        src = c[14] ? bypass_i : pt_sum_i;
        case (c[1:0])
            2'd0: return src;
            2'd1: return ~src;
            2'd2: return src ^ pt_xor_i;
            default: return ~(src ^ pt_xor_i);
        endcase
    endfunction

    // R5: expected selected cell clock.
    function automatic logic f_clk(logic [14:0] c);
        case (c[6:4])
            3'd0: return gclk_i[0];
            3'd1: return gclk_i[1];
            3'd2: return gclk_i[2];
            3'd3: return gclk_i[3];
            3'd4: return pt_clk_i;
            3'd5: return sh_clk_i;
            default: return 1'b0;
        endcase
    endfunction

    // R6: expected enable.
    function automatic logic f_ce(logic [14:0] c);
        case (c[8:7])
            2'd0: return 1'b1;
            2'd1: return gce_i;
            2'd2: return sh_ce_i;
            default: return gce_i & sh_ce_i;
        endcase
    endfunction

    // R7: expected cell reset.
    function automatic logic f_rst(logic [14:0] c);
        case (c[10:9])
            2'd0: return 1'b0;
            2'd1: return grst_i;
            2'd2: return pt_rst_i;
            default: return sh_rst_i;
        endcase
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        pt_sum_i = 0; bypass_i = 0; pt_xor_i = 0; pad_i = 0;
        gclk_i = '0; pt_clk_i = 0; sh_clk_i = 0; gce_i = 0; sh_ce_i = 0;
        grst_i = 0; pt_rst_i = 0; sh_rst_i = 0; pt_pre_i = 0;
    endtask

    // R10: reset with a configuration; stored value and clock history go to 0.
    task automatic do_reset(logic [14:0] c);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_i = c;
        drive_idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_q = 1'b0;
        m_prev = 1'b0;
    endtask

    // Advance the model across one clk edge (R2, R3, R4, R6, R7, R8).
    task automatic model_step(logic [14:0] c);
        logic ck, d;
        ck = f_clk(c);
        d  = c[2] ? pad_i : f_comb(c);
        if (f_rst(c))                     m_q = 1'b0;
        else if (c[11] && pt_pre_i)       m_q = 1'b1;
        else if (f_ce(c) && (c[3] ? ck : (ck && !m_prev))) m_q = d;
        m_prev = ck;
    endtask

    function automatic string reg_tag(logic [14:0] c);
        if (c[10:9] != 2'd0) return "R7";
        if (c[11])           return "R8";
        if (c[3])            return "R4";
        return "R3";
    endfunction

    initial begin
        logic [14:0] c;
        rst_n = 1'b0;
        cfg_i = '0;
        drive_idle();

        // Directed: route registered, io combinational, global clock 0, always enabled.
        c = 15'h1000;
        do_reset(c);
        #1;
        check("R10", "route_o reset state", route_o, 1'b0);
        check("R9", "io_o comb at reset", io_o, 1'b0);
        // R10: a new configuration after reset must be ignored.
        cfg_i = 15'h0000;
        pt_sum_i = 1'b1;
        #1;
        check("R10", "route_o after cfg change", route_o, 1'b0);
        check("R9", "io_o follows comb", io_o, 1'b1);
        gclk_i[0] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R3", "route_o after edge", route_o, 1'b1);
        check("R9", "io_o still comb", io_o, 1'b1);

        // Sweep: clock code, latch, enable code, reset code, preset enable.
        for (int k = 0; k < N_CFG; k++) begin
            c = '0;
            c[6:4]  = k[2:0];
            c[3]    = k[3];
            c[8:7]  = k[5:4];
            c[10:9] = k[7:6];
            c[11]   = k[8];
            c[1:0]  = k[1:0] ^ k[5:4];
            c[2]    = k[4] ^ k[0];
            c[12]   = k[0] ^ k[6];
            c[13]   = k[1] ^ k[7];
            c[14]   = k[2] ^ k[8];
            do_reset(c);
            cfg_i = ~c;  // R10: ignored after reset
            for (int n = 0; n < CYC_PER_CFG; n++) begin
                logic e_comb;
                rnd = next_rand(rnd);
                pt_sum_i = rnd[0];  bypass_i = rnd[1];  pt_xor_i = rnd[2];
                pad_i    = rnd[3];  gclk_i   = rnd[7:4];
                pt_clk_i = rnd[8];  sh_clk_i = rnd[9];
                gce_i    = rnd[10] | rnd[11];
                sh_ce_i  = rnd[12] | rnd[13];
                grst_i   = rnd[14] & rnd[15] & rnd[16];
                pt_rst_i = rnd[17] & rnd[18] & rnd[19];
                sh_rst_i = rnd[20] & rnd[21] & rnd[22];
                pt_pre_i = rnd[23] & rnd[24];
                #1;
                e_comb = f_comb(c);
                // R9: each output independently stored or combinational.
                check(c[12] ? reg_tag(c) : "R1", "route_o", route_o, c[12] ? m_q : e_comb);
                check(c[13] ? reg_tag(c) : "R1", "io_o",    io_o,    c[13] ? m_q : e_comb);
                @(posedge clk);
                model_step(c);
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule